// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps the interrupt vector table for a device function that raises message-signalled interrupts. Each vector holds a 64-bit target address, a 32-bit payload word and its own mask bit. A packed pending-bit array records requests that arrived while their vector could not send. Software reaches the table through a 32-bit register port and reads the pending array through a separate read-only 32-bit port. The two function-level control bits, enable and mask-all, are loaded by a control-byte write strobe.

Device logic raises interrupts by presenting a vector index on the request port. A vector only accepts requests while its in-use count is non-zero. The count is raised and lowered by the device through its own strobes. An accepted request for a vector that is not masked becomes one posted memory write, offered on a valid/ready message port. An accepted request for a masked vector sets the vector's pending bit instead. Whenever a vector's effective mask goes from set to clear, the held request is replayed automatically. The cause can be a table write, a control write or both at once. A one-cycle pulse tells the legacy wire-interrupt logic to drop its line each time the function is written with enable set.

Top module: `msix_vector_ctrl`

## Requirements
- R1: After reset, enable and mask-all are clear. Every table address, address-high and data word reads 0, every vector-control word reads 1 (masked), all pending bits read 0, all in-use counts are 0, no message is offered and the wire-interrupt pulse is low.
- R2: Each vector owns 16 bytes of table space and is selected by byte offset divided by 16. Offset 0 holds address bits 31:0, offset 4 holds address bits 63:32, offset 8 holds the data word, and offset 12 is vector control, whose bit 0 is the mask and whose other bits read 0. Offsets past the last vector read 0 and ignore writes.
- R3: A table write takes effect only when all four byte enables are set and the byte address is a multiple of 4; any other write leaves the table unchanged.
- R4: A vector is masked while enable is clear, while mask-all is set, or while its own mask bit is set.
- R5: A request whose index is not below the vector count, or whose vector has an in-use count of 0, produces no message and leaves the pending array unchanged.
- R6: An accepted request for a masked vector sets its pending bit and sends nothing. An accepted request for an unmasked vector sends one message carrying {address-high, address-low} and the data word.
- R7: Vector v's pending bit is bit v mod 8 of byte v/8, so that in the 32-bit pending port it is bit v mod 32 of the word at byte address 4*(v/32). The array spans the vector count rounded up to a multiple of 64 bits. Bits with no vector read 0, and the port has no write path.
- R8: When a vector's effective mask goes from set to clear while its pending bit is set, the bit clears and one message for that vector is sent. Any cause of the change counts: a vector-control write, setting enable or clearing mask-all.
- R9: A change to enable or mask-all re-evaluates every vector at once against its own mask bit. Vectors whose own bit is still set keep their pending bit.
- R10: A control write with enable set produces a one-cycle pulse on intx_deassert in the following cycle. A control write with enable clear produces none.
- R11: In-use increments and decrements adjust the vector's count. A decrement that brings the count to 0 clears the vector's pending bit, and a decrement of a count already at 0 is ignored.
- R12: Among vectors waiting to send, the lowest index goes first. An offered message keeps its address and data until accepted. A request for a vector whose message is waiting but not yet offered merges into that message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control-byte write strobe |
| ctl_enable | input | 1 | Function enable value written by ctl_we |
| ctl_maskall | input | 1 | Function mask-all value written by ctl_we |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | TAW | Table byte address |
| tbl_be | input | 4 | Table write byte enables |
| tbl_wdata | input | 32 | Table write data |
| tbl_rdata | output | 32 | Table read data for tbl_addr |
| pba_addr | input | PAW | Pending-array byte address |
| pba_rdata | output | 32 | Pending-array read data |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | IW | Requested vector index |
| use_inc | input | 1 | Raise the in-use count of use_vec |
| use_dec | input | 1 | Lower the in-use count of use_vec |
| use_vec | input | IW | Vector index for the in-use strobes |
| msg_valid | output | 1 | Message write offered |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |
| intx_deassert | output | 1 | Pulse telling legacy interrupt logic to drop its line |

## Verification
The bench builds the block with twelve vectors and a 3-bit in-use count. Twelve is not a power of two, so the table decode covers four vector slots that do not exist. These slots, together with request indices 12 to 15, exercise the out-of-range drops and read-as-zero cases. Vectors 8 to 11 land in the second pending byte, and the pending port's second word exists but must stay zero. Replays that release several vectors in one cycle, a stalled message port and repeated requests to a queued vector check the ordering, the hold and the merging.

// File: rtl/msix_vector_ctrl.sv
module msix_vector_ctrl #(
  parameter int NVEC = 8,
  parameter int CNTW = 4,
  localparam int VW = (NVEC > 1) ? $clog2(NVEC) : 1,
  localparam int IW = VW + 1,
  localparam int TAW = VW + 4,
  localparam int PBITS = ((NVEC + 63) / 64) * 64,
  localparam int PAW = $clog2(PBITS / 8)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_we,
  input  logic           ctl_enable,
  input  logic           ctl_maskall,
  input  logic           tbl_we,
  input  logic [TAW-1:0] tbl_addr,
  input  logic [3:0]     tbl_be,
  input  logic [31:0]    tbl_wdata,
  output logic [31:0]    tbl_rdata,
  input  logic [PAW-1:0] pba_addr,
  output logic [31:0]    pba_rdata,
  input  logic           req_valid,
  input  logic [IW-1:0]  req_vec,
  input  logic           use_inc,
  input  logic           use_dec,
  input  logic [IW-1:0]  use_vec,
  output logic           msg_valid,
  input  logic           msg_ready,
  output logic [63:0]    msg_addr,
  output logic [31:0]    msg_data,
  output logic           intx_deassert
);

  logic            en_q, mall_q, intx_q;
  logic [31:0]     alo [NVEC];
  logic [31:0]     ahi [NVEC];
  logic [31:0]     dat [NVEC];
  logic [CNTW-1:0] use_q [NVEC];
  logic [NVEC-1:0] vmask_q, pend_q, send_q;
  logic            mv_q;
  logic [63:0]     ma_q;
  logic [31:0]     md_q;

  logic [VW-1:0]   tvec;
  logic [1:0]      tfld;
  logic            tin, wr_ok;
  assign tvec  = tbl_addr[TAW-1:4];
  assign tfld  = tbl_addr[3:2];
  assign tin   = {1'b0, tvec} < IW'(NVEC);
  assign wr_ok = tbl_we && (tbl_be == 4'hF) && (tbl_addr[1:0] == 2'b00) && tin;

  logic en_n, mall_n, fm_old, fm_new;
  assign en_n   = ctl_we ? ctl_enable  : en_q;
  assign mall_n = ctl_we ? ctl_maskall : mall_q;
  assign fm_old = !en_q || mall_q;
  assign fm_new = !en_n || mall_n;

  logic [NVEC-1:0] vmask_n, masked_old, masked_new, replay;
  logic [NVEC-1:0] inc_v, dec_v, hit_v, clr_v, send_set, sel_oh;
  logic [VW-1:0]   sel;
  logic            load;

  always_comb begin
    vmask_n = vmask_q;
    if (wr_ok && tfld == 2'd3) vmask_n[tvec] = tbl_wdata[0];
    for (int i = 0; i < NVEC; i++) begin
      inc_v[i] = use_inc && (use_vec == IW'(i));
      dec_v[i] = use_dec && (use_vec == IW'(i));
      hit_v[i] = req_valid && (req_vec == IW'(i)) && (use_q[i] != '0);
      clr_v[i] = dec_v[i] && !inc_v[i] && (use_q[i] == CNTW'(1));
    end
  end

  assign masked_old = {NVEC{fm_old}} | vmask_q;
  assign masked_new = {NVEC{fm_new}} | vmask_n;
  assign replay     = masked_old & ~masked_new & pend_q;
  assign send_set   = replay | (hit_v & ~masked_new);

  always_comb begin
    sel = '0;
    for (int i = NVEC - 1; i >= 0; i--)
      if (send_q[i]) sel = VW'(i);
  end

  assign load   = (|send_q) && (!mv_q || msg_ready);
  assign sel_oh = load ? (NVEC'(1) << sel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mall_q  <= 1'b0;
      intx_q  <= 1'b0;
      vmask_q <= '1;
      pend_q  <= '0;
      send_q  <= '0;
      mv_q    <= 1'b0;
      ma_q    <= '0;
      md_q    <= '0;
      for (int i = 0; i < NVEC; i++) begin
        alo[i]   <= '0;
        ahi[i]   <= '0;
        dat[i]   <= '0;
        use_q[i] <= '0;
      end
    end else begin
      en_q    <= en_n;
      mall_q  <= mall_n;
      intx_q  <= ctl_we && ctl_enable;
      vmask_q <= vmask_n;
      pend_q  <= (pend_q | (hit_v & masked_new)) & ~replay & ~clr_v;
      send_q  <= (send_q & ~sel_oh) | send_set;
      if (wr_ok) begin
        case (tfld)
          2'd0:    alo[tvec] <= tbl_wdata;
          2'd1:    ahi[tvec] <= tbl_wdata;
          2'd2:    dat[tvec] <= tbl_wdata;
          default: ;
        endcase
      end
      for (int i = 0; i < NVEC; i++) begin
        if (inc_v[i] && !dec_v[i] && use_q[i] != '1)
          use_q[i] <= use_q[i] + CNTW'(1);
        else if (dec_v[i] && !inc_v[i] && use_q[i] != '0)
          use_q[i] <= use_q[i] - CNTW'(1);
      end
      if (load) begin
        mv_q <= 1'b1;
        ma_q <= {ahi[sel], alo[sel]};
        md_q <= dat[sel];
      end else if (msg_ready) begin
        mv_q <= 1'b0;
      end
    end
  end

  always_comb begin
    tbl_rdata = '0;
    if (tin) begin
      case (tfld)
        2'd0:    tbl_rdata = alo[tvec];
        2'd1:    tbl_rdata = ahi[tvec];
        2'd2:    tbl_rdata = dat[tvec];
        default: tbl_rdata = {31'b0, vmask_q[tvec]};
      endcase
    end
  end

  logic [PBITS-1:0] pend_pad;
  assign pend_pad  = PBITS'(pend_q);
  assign pba_rdata = pend_pad[pba_addr[PAW-1:2]*32 +: 32];

  assign msg_valid     = mv_q;
  assign msg_addr      = ma_q;
  assign msg_data      = md_q;
  assign intx_deassert = intx_q;

  // R12
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R10
  intx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intx_deassert |-> $past(ctl_we && ctl_enable));

  // R8
  pend_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~({NVEC{!en_q || mall_q}} | vmask_q)) == '0);

  for (genvar g = 0; g < NVEC; g++) begin : g_chk
    // R11
    pend_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[g] |-> use_q[g] != '0);
  end

endmodule

// File: tb/tb_msix_vector_ctrl.sv
module tb_msix_vector_ctrl;
  localparam int NVEC = 12;
  localparam int CNTW = 3;
  localparam int TAW = 8;
  localparam int PAW = 3;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 0, ctl_enable = 0, ctl_maskall = 0;
  logic tbl_we = 0;
  logic [TAW-1:0] tbl_addr = '0;
  logic [3:0] tbl_be = 4'hF;
  logic [31:0] tbl_wdata = '0;
  logic [31:0] tbl_rdata;
  logic [PAW-1:0] pba_addr = '0;
  logic [31:0] pba_rdata;
  logic req_valid = 0;
  logic [IW-1:0] req_vec = '0;
  logic use_inc = 0, use_dec = 0;
  logic [IW-1:0] use_vec = '0;
  logic msg_valid, msg_ready;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  logic intx_deassert;
  logic rdy = 1'b1;
  assign msg_ready = rdy;

  always #2 clk = ~clk;

  msix_vector_ctrl #(.NVEC(NVEC), .CNTW(CNTW)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
    .ctl_maskall(ctl_maskall), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_be(tbl_be), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
    .pba_addr(pba_addr), .pba_rdata(pba_rdata), .req_valid(req_valid),
    .req_vec(req_vec), .use_inc(use_inc), .use_dec(use_dec), .use_vec(use_vec),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data), .intx_deassert(intx_deassert));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [95:0] expq[$];

  function automatic logic [95:0] mk(int v);
    return {32'(v), 32'h2000_0000 + 32'(v * 16), 32'hA000 + 32'(v)};
  endfunction

  task automatic check(bit ok, string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #1;
    if (rst_n && msg_valid && msg_ready) begin
      if (expq.size() == 0)
        check(0, "R6 unexpected message", {msg_addr, msg_data}, '0);
      else begin
        logic [95:0] e;
        e = expq.pop_front();
        check({msg_addr, msg_data} == e, "R12 message order/content", {msg_addr, msg_data}, e);
      end
    end
  end

  task automatic tw(int addr, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    tbl_we = 1; tbl_addr = TAW'(addr); tbl_wdata = d; tbl_be = be;
    @(negedge clk);
    tbl_we = 0; tbl_be = 4'hF;
  endtask

  task automatic trd(int addr, logic [31:0] exp, string tag);
    @(negedge clk);
    tbl_addr = TAW'(addr);
    #1 check(tbl_rdata == exp, tag, tbl_rdata, exp);
  endtask

  task automatic pchk(int word, logic [31:0] exp, string tag);
    pba_addr = PAW'(word * 4);
    #1 check(pba_rdata == exp, tag, pba_rdata, exp);
  endtask

  task automatic cw(bit en, bit ma);
    @(negedge clk);
    ctl_we = 1; ctl_enable = en; ctl_maskall = ma;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic rq(int v);
    @(negedge clk);
    req_valid = 1; req_vec = IW'(v);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic uo(bit inc, bit dec, int v);
    @(negedge clk);
    use_inc = inc; use_dec = dec; use_vec = IW'(v);
    @(negedge clk);
    use_inc = 0; use_dec = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((expq.size() != 0 || msg_valid) && n < 300) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R12 expected messages delivered", 96'(expq.size()), '0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    trd(0 * 16 + 12, 32'd1, "R1 v0 control masked");
    trd(11 * 16 + 12, 32'd1, "R1 v11 control masked");
    trd(3 * 16 + 0, 32'd0, "R1 v3 address low zero");
    pchk(0, 0, "R1 pending word0 zero");
    pchk(1, 0, "R1 pending word1 zero");
    check(!msg_valid && !intx_deassert, "R1 outputs idle", {msg_valid, intx_deassert}, '0);

    // R2 layout
    tw(3 * 16 + 0, 32'h1000_0030);
    tw(3 * 16 + 4, 32'h0000_0001);
    tw(3 * 16 + 8, 32'h0000_00D3);
    trd(3 * 16 + 0, 32'h1000_0030, "R2 address low");
    trd(3 * 16 + 4, 32'h0000_0001, "R2 address high");
    trd(3 * 16 + 8, 32'h0000_00D3, "R2 data");
    tw(3 * 16 + 12, 32'hFFFF_FFFF);
    trd(3 * 16 + 12, 32'd1, "R2 control reads mask only");
    tw(13 * 16 + 8, 32'h5555_5555);
    trd(13 * 16 + 8, 32'd0, "R2 out-of-range reads zero");

    // R3 access width
    tw(3 * 16 + 8, 32'hDEAD_BEEF, 4'h3);
    trd(3 * 16 + 8, 32'h0000_00D3, "R3 partial byte enables ignored");
    tw(3 * 16 + 9, 32'hDEAD_BEEF);
    trd(3 * 16 + 8, 32'h0000_00D3, "R3 misaligned write ignored");

    for (int v = 0; v < NVEC; v++) begin
      logic [95:0] m;
      m = mk(v);
      tw(v * 16 + 0, m[63:32]);
      tw(v * 16 + 4, m[95:64]);
      tw(v * 16 + 8, m[31:0]);
    end
    for (int v = 0; v < NVEC - 1; v++) uo(1, 0, v);

    // R5 drops
    cw(1, 0);
    tw(11 * 16 + 12, 0);
    rq(11);
    rq(13);
    repeat (4) @(negedge clk);
    pchk(0, 0, "R5 unused/out-of-range request leaves pending");
    check(!msg_valid, "R5 no message for dropped requests", msg_valid, 0);

    // R6 direct and masked requests
    tw(2 * 16 + 12, 0);
    expq.push_back(mk(2));
    rq(2);
    wait_idle();
    rq(4);
    pchk(0, 32'h10, "R6 masked request sets pending");
    repeat (3) @(negedge clk);
    check(!msg_valid, "R6 masked request sends nothing", msg_valid, 0);

    // R8 replay on vector unmask
    expq.push_back(mk(4));
    tw(4 * 16 + 12, 0);
    pchk(0, 0, "R8 pending cleared on unmask");
    wait_idle();

    // R4, R7, R9, R10
    cw(1, 1);
    #1 check(intx_deassert == 1'b1, "R10 pulse after enabled write", intx_deassert, 1);
    @(negedge clk);
    #1 check(intx_deassert == 1'b0, "R10 pulse lasts one cycle", intx_deassert, 0);
    rq(2);
    rq(9);
    rq(5);
    pchk(0, 32'h224, "R7 bits 2,5,9 packed (byte1 bit1)");
    pchk(1, 0, "R7 padding word reads zero");
    tw(5 * 16 + 12, 0);
    pchk(0, 32'h224, "R4 mask-all keeps vector masked");
    expq.push_back(mk(2));
    expq.push_back(mk(5));
    cw(1, 0);
    wait_idle();
    pchk(0, 32'h200, "R9 own-masked vector stays pending");
    cw(0, 0);
    #1 check(intx_deassert == 1'b0, "R10 no pulse when enable clear", intx_deassert, 0);
    tw(9 * 16 + 12, 0);
    pchk(0, 32'h200, "R4 disabled function keeps vector masked");
    expq.push_back(mk(9));
    cw(1, 0);
    wait_idle();
    pchk(0, 0, "R8 replay on enable");

    // R11 use counts
    tw(5 * 16 + 12, 1);
    rq(5);
    pchk(0, 32'h20, "R11 pending before release");
    uo(0, 1, 5);
    pchk(0, 0, "R11 count to zero clears pending");
    uo(0, 1, 5);
    rq(5);
    pchk(0, 0, "R11 decrement at zero ignored");
    uo(1, 0, 5);
    uo(1, 0, 5);
    uo(0, 1, 5);
    rq(5);
    pchk(0, 32'h20, "R11 count still non-zero");
    expq.push_back(mk(5));
    tw(5 * 16 + 12, 0);
    wait_idle();

    // R12 priority and hold
    cw(1, 1);
    tw(1 * 16 + 12, 0);
    tw(3 * 16 + 12, 0);
    tw(7 * 16 + 12, 0);
    rq(7);
    rq(3);
    rq(1);
    pchk(0, 32'h8A, "R9 three vectors pending under mask-all");
    rdy = 0;
    expq.push_back(mk(1));
    expq.push_back(mk(3));
    expq.push_back(mk(7));
    cw(1, 0);
    repeat (4) @(negedge clk);
    #1 check(msg_valid && {msg_addr, msg_data} == mk(1), "R12 lowest offered first",
             {msg_addr, msg_data}, mk(1));
    repeat (3) @(negedge clk);
    #1 check(msg_valid && {msg_addr, msg_data} == mk(1), "R12 held while stalled",
             {msg_addr, msg_data}, mk(1));
    rdy = 1;
    wait_idle();

    // R12 merge
    rdy = 0;
    expq.push_back(mk(1));
    expq.push_back(mk(1));
    expq.push_back(mk(3));
    rq(1);
    repeat (2) @(negedge clk);
    rq(3);
    rq(3);
    rq(1);
    repeat (3) @(negedge clk);
    pchk(0, 0, "R12 queued requests not pending");
    rdy = 1;
    wait_idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule